// File: doc/BRIEF.md
# Flash Block Protection Controller

This block sits between a requester and a behavioural flash array and serves four kinds of request: data read, instruction fetch, word program and page erase. The array is split into erase pages, and every pair of neighbouring pages forms one protection region carrying a two-bit attribute. A forbidden request is refused with an error flag and never reaches the array. Program and erase occupy the controller for a fixed number of cycles; every request, accepted or refused, ends with a single-cycle done pulse.

The full-size configuration is 256 pages of 256 words of 32 bits, which gives 256 KB and 128 regions. The default parameters use a small array of 8 pages of 16 words, so 4 regions, which keeps elaboration and exhaustive sweeps cheap. Protection attributes are written through a separate configuration port. They can only become stricter until reset.

The controller is one state machine with four states. ST_IDLE accepts a request and moves on as follows: a refused request or an allowed read or fetch goes to ST_DONE; an allowed program goes to ST_PROG; an allowed erase goes to ST_ERASE. ST_PROG and ST_ERASE count down their cycle budget, commit to the array on the last count, and then go to ST_DONE. ST_DONE raises done for one cycle and returns to ST_IDLE.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_done and rsp_err are 0, every region has attribute 00, and every array word reads as all ones.
- R2: An allowed data read (req_op 0) or instruction fetch (req_op 1) returns the addressed word on rsp_rdata. rsp_done is high, with rsp_err low, in the cycle right after acceptance.
- R3: An allowed program (req_op 2) stores old_word AND req_wdata, so a 0 bit can never return to 1. rsp_done rises PROG_CYCLES+1 cycles after acceptance.
- R4: An allowed erase (req_op 3) sets every word of the page holding req_addr to all ones. The other page of the same region and all other pages are unchanged. rsp_done rises ERASE_CYCLES+1 cycles after acceptance.
- R5: A region is addressed as word address / (2*PAGE_WORDS). A configuration write ORs cfg_attr into that region's attribute, so a write that would clear a bit has no effect.
- R6: Attribute bit 0 (read-only) refuses program and erase but allows data read and fetch.
- R7: Attribute bit 1 (execute-only) refuses program, erase and data read but allows fetch. A refused data read returns rsp_rdata of 0.
- R8: A refused request leaves the array unchanged. It completes with rsp_done and rsp_err both high in the cycle right after acceptance.
- R9: req_ready is low from the cycle after acceptance through the done cycle. Requests presented while req_ready is low are ignored.
- R10: rsp_err is high only together with rsp_done, and rsp_done never lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on this clock edge |
| req_op | input | 2 | 0 data read, 1 fetch, 2 program, 3 erase |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Program data |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_region | input | REGION_W | Region being configured |
| cfg_attr | input | 2 | Bits to set: bit 0 read-only, bit 1 execute-only |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request was refused (valid with rsp_done) |
| rsp_rdata | output | WORD_W | Read or fetch result |

## Verification
The properties assume that req_valid, req_op and the configuration inputs are never unknown after reset, and that every 2-bit op value is meaningful. The bench satisfies this by driving every input to a defined value from time zero and changing inputs only on falling edges. The sticky-attribute property also assumes that an attribute cannot change except through cfg_we. The bench deliberately issues configuration writes that try to clear bits, and it presents requests while the controller is busy.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_FETCH = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } fpc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_DONE  = 2'd3
    } fpc_state_e;

    localparam int ATTR_W = 2;

    // bit 0: modify lock, bit 1: data-read lock (also locks modification)
    function automatic logic fpc_denied(input fpc_op_e op, input logic [ATTR_W-1:0] attr);
        logic deny;
        unique case (op)
            OP_READ:  deny = attr[1];
            OP_FETCH: deny = 1'b0;
            OP_PROG,
            OP_ERASE: deny = attr[0] | attr[1];
            default:  deny = 1'b1;
        endcase
        return deny;
    endfunction

endpackage

// File: rtl/fpc_attr_table.sv
module fpc_attr_table
    import fpc_pkg::*;
#(
    parameter int REGIONS  = 4,
    parameter int REGION_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [REGION_W-1:0]         cfg_region,
    input  logic [ATTR_W-1:0]           cfg_attr,
    output logic [REGIONS*ATTR_W-1:0]   attr_flat
);

    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        logic [ATTR_W-1:0] attr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q <= '0;
            end else if (cfg_we && cfg_region == REGION_W'(r)) begin
                attr_q <= attr_q | cfg_attr;
            end
        end

        assign attr_flat[r*ATTR_W +: ATTR_W] = attr_q;
    end

endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 128,
    parameter int PAGE_WORDS = 16,
    parameter int ADDR_W     = 7,
    parameter int PAGE_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              er_en,
    input  logic [PAGE_W-1:0] er_page
);

    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              in_page;
        logic              hit;

        assign in_page = (er_page == PAGE_W'(i / PAGE_WORDS));
        assign hit     = (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (er_en && in_page) begin
                word_q <= '1;
            end else if (wr_en && hit) begin
                word_q <= word_q & wr_data;
            end
        end

        assign words[i] = word_q;
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int ADDR_W       = 7,
    parameter int PAGE_OFF_W   = 4,
    parameter int PROG_CYCLES  = 3,
    parameter int ERASE_CYCLES = 6,
    localparam int PAGE_W      = ADDR_W - PAGE_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  fpc_op_e           req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [ATTR_W-1:0] attr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              req_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              er_en,
    output logic [PAGE_W-1:0] er_page,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fpc_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;
    logic [WORD_W-1:0] rdata_q;
    logic              accept;
    logic              deny;
    logic              last;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign deny   = fpc_denied(req_op, attr);
    assign last   = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (deny) begin
                        state_d = ST_DONE;
                    end else begin
                        unique case (req_op)
                            OP_PROG:  state_d = ST_PROG;
                            OP_ERASE: state_d = ST_ERASE;
                            default:  state_d = ST_DONE;
                        endcase
                    end
                end
            end
            ST_PROG:  if (last) state_d = ST_DONE;
            ST_ERASE: if (last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            err_q  <= deny;
            if (deny) begin
                rdata_q <= '0;
            end else if (req_op == OP_READ || req_op == OP_FETCH) begin
                rdata_q <= rd_data;
            end
            cnt_q <= (req_op == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1)
                                          : CNT_W'(PROG_CYCLES - 1);
        end else if ((state_q == ST_PROG || state_q == ST_ERASE) && !last) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_DONE);
        rsp_err   = (state_q == ST_DONE) && err_q;
        wr_en     = (state_q == ST_PROG) && last;
        er_en     = (state_q == ST_ERASE) && last;
        wr_addr   = addr_q;
        wr_data   = data_q;
        er_page   = addr_q[ADDR_W-1:PAGE_OFF_W];
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
    import fpc_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int PAGE_WORDS    = 16,
    parameter int NUM_PAGES     = 8,
    parameter int PROG_CYCLES   = 3,
    parameter int ERASE_CYCLES  = 6,
    localparam int NUM_WORDS    = PAGE_WORDS * NUM_PAGES,
    localparam int ADDR_W       = $clog2(NUM_WORDS),
    localparam int PAGE_OFF_W   = $clog2(PAGE_WORDS),
    localparam int PAGE_W       = ADDR_W - PAGE_OFF_W,
    localparam int REGIONS      = NUM_PAGES / 2,
    localparam int REGION_W     = PAGE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic                cfg_we,
    input  logic [REGION_W-1:0] cfg_region,
    input  logic [1:0]          cfg_attr,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic [WORD_W-1:0]   rsp_rdata
);

    logic [REGIONS*ATTR_W-1:0] attr_flat;
    logic [REGION_W-1:0]       lk_region;
    logic [ATTR_W-1:0]         lk_attr;
    logic [WORD_W-1:0]         rd_data;
    logic                      wr_en;
    logic [ADDR_W-1:0]         wr_addr;
    logic [WORD_W-1:0]         wr_data;
    logic                      er_en;
    logic [PAGE_W-1:0]         er_page;

    assign lk_region = req_addr[ADDR_W-1 -: REGION_W];
    assign lk_attr   = attr_flat[lk_region*ATTR_W +: ATTR_W];

    fpc_attr_table #(
        .REGIONS  (REGIONS),
        .REGION_W (REGION_W)
    ) u_attr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_attr   (cfg_attr),
        .attr_flat  (attr_flat)
    );

    fpc_array #(
        .WORD_W     (WORD_W),
        .NUM_WORDS  (NUM_WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .er_en   (er_en),
        .er_page (er_page)
    );

    fpc_seq #(
        .WORD_W       (WORD_W),
        .ADDR_W       (ADDR_W),
        .PAGE_OFF_W   (PAGE_OFF_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (fpc_op_e'(req_op)),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .attr      (lk_attr),
        .rd_data   (rd_data),
        .req_ready (req_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .er_en     (er_en),
        .er_page   (er_page),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int ATTR_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [1:0]           req_op,
    input logic                 rsp_done,
    input logic                 rsp_err,
    input logic [ATTR_BITS-1:0] attr_flat
);

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);                                          // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);                                        // R10

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);                                       // R9

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                       // R9

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_op[1]) |=> rsp_done);           // R2

    AST_ATTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((attr_flat & $past(attr_flat)) == $past(attr_flat))); // R5

endmodule

bind flash_prot_ctrl fpc_checker #(.ATTR_BITS(2*REGIONS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .attr_flat (attr_flat)
);

// File: tb/sim_flash_prot_ctrl.sv
`timescale 1ns/1ps
module sim_flash_prot_ctrl;

    localparam int PW   = 16;
    localparam int NP   = 8;
    localparam int NW   = PW * NP;
    localparam int RW   = 2 * PW;
    localparam int NR   = NP / 2;
    localparam int PCYC = 3;
    localparam int ECYC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_region = '0;
    logic [1:0]  cfg_attr = '0;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [NW];
    logic [1:0]  amodel [NR];

    always #5 clk = ~clk;

    flash_prot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_attr(cfg_attr),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic run_op(input logic [1:0] op, input int addr, input logic [31:0] data,
                          output logic err, output logic [31:0] rd, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr[6:0]; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        err = rsp_err;
        rd  = rsp_rdata;
    endtask

    task automatic set_attr(input int r, input logic [1:0] a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = r[1:0]; cfg_attr = a;
        @(negedge clk);
        cfg_we = 1'b0;
        amodel[r] = amodel[r] | a;
    endtask

    function automatic bit denied(input logic [1:0] op, input logic [1:0] a);
        if (op == 2'd1) return 1'b0;
        if (op == 2'd0) return a[1];
        return a[0] | a[1];
    endfunction

    function automatic int exp_lat(input logic [1:0] op, input bit d);
        if (d || op < 2) return 1;
        return (op == 2'd2) ? PCYC + 1 : ECYC + 1;
    endfunction

    task automatic readback_all(input logic [1:0] op, input string tag);
        logic e; logic [31:0] rd; int lat;
        for (int a = 0; a < NW; a++) begin
            run_op(op, a, 32'h0, e, rd, lat);
            check(rd == model[a] && !e && lat == 1, tag, rd, model[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic e; logic [31:0] rd; int lat;
        for (int i = 0; i < NW; i++) model[i] = '1;
        for (int r = 0; r < NR; r++) amodel[r] = 2'b00;

        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && rsp_done === 1'b0 && rsp_err === 1'b0,
              "R1 reset outputs", {29'd0, req_ready, rsp_done, rsp_err}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased array after reset
        readback_all(2'd0, "R1 erased read");

        // R3: program pattern, then a second one that must AND in
        for (int a = 0; a < NW; a++) begin
            logic [31:0] d;
            d = (32'(a) * 32'h9E3779B1) ^ 32'hF0F0_0F0F;
            run_op(2'd2, a, d, e, rd, lat);
            model[a] = model[a] & d;
            check(!e && lat == PCYC + 1, "R3 program latency", 32'(lat), 32'(PCYC + 1));
        end
        for (int a = 0; a < NW; a += 3) begin
            logic [31:0] d;
            d = ~(32'(a) << 5) | 32'h0000_00FF;
            run_op(2'd2, a, d, e, rd, lat);
            model[a] = model[a] & d;
        end
        readback_all(2'd0, "R3 and-merge read");
        readback_all(2'd1, "R2 fetch read");

        // R4: erase one page of a pair
        run_op(2'd3, 2 * PW + 7, 32'h0, e, rd, lat);
        check(!e && lat == ECYC + 1, "R4 erase latency", 32'(lat), 32'(ECYC + 1));
        for (int a = 2 * PW; a < 3 * PW; a++) model[a] = '1;
        readback_all(2'd0, "R4 erase page scope");

        // R9: requests presented while busy are ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 7'(PW);
        @(negedge clk);
        req_op = 2'd2; req_addr = 7'(5 * PW + 1); req_wdata = 32'h0;
        check(req_ready == 1'b0, "R9 busy not ready", {31'd0, req_ready}, 32'h0);
        @(negedge clk);
        req_op = 2'd3; req_addr = 7'(6 * PW);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 3;
        while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
        check(lat == ECYC + 1 && !rsp_err, "R9 erase under stalled requests", 32'(lat), 32'(ECYC + 1));
        for (int a = PW; a < 2 * PW; a++) model[a] = '1;
        readback_all(2'd1, "R9 stalled requests ignored");

        // R6 R7 R8: every attribute against every operation
        set_attr(1, 2'b01);
        set_attr(2, 2'b10);
        set_attr(3, 2'b11);
        for (int r = 0; r < NR; r++) begin
            for (int o = 0; o < 4; o++) begin
                int a;
                bit d;
                a = (o == 3) ? r * RW + PW + 2 : r * RW + 4 + o;
                d = denied(o[1:0], amodel[r]);
                run_op(o[1:0], a, 32'h0F0F_3C3C, e, rd, lat);
                check(e == d, d ? "R8 refusal flagged" : "R6 R7 allowed op", {31'd0, e}, {31'd0, d});
                check(lat == exp_lat(o[1:0], d), "R8 completion latency", 32'(lat), 32'(exp_lat(o[1:0], d)));
                if (o < 2) begin
                    check(rd == (d ? 32'h0 : model[a]), "R7 read result", rd, d ? 32'h0 : model[a]);
                end else if (!d) begin
                    if (o == 2) model[a] = model[a] & 32'h0F0F_3C3C;
                    else for (int w = r * RW + PW; w < r * RW + RW; w++) model[w] = '1;
                end
            end
        end
        readback_all(2'd1, "R8 array untouched by refusals");

        // R5: relaxing ignored, OR merge, tightening works
        set_attr(1, 2'b00);
        run_op(2'd2, RW + 1, 32'h0, e, rd, lat);
        check(e == 1'b1, "R5 relax ignored", {31'd0, e}, 32'h1);
        set_attr(1, 2'b10);
        run_op(2'd0, RW + 1, 32'h0, e, rd, lat);
        check(e == 1'b1 && rd == 32'h0, "R5 or-merge locks read", rd, 32'h0);
        run_op(2'd1, RW + 1, 32'h0, e, rd, lat);
        check(e == 1'b0 && rd == model[RW + 1], "R7 fetch still allowed", rd, model[RW + 1]);
        set_attr(0, 2'b01);
        run_op(2'd3, 0, 32'h0, e, rd, lat);
        check(e == 1'b1 && lat == 1, "R6 tightened region refuses erase", 32'(lat), 32'h1);
        run_op(2'd0, 0, 32'h0, e, rd, lat);
        check(e == 1'b0 && rd == model[0], "R6 read-only region readable", rd, model[0]);
        readback_all(2'd1, "R8 final array state");

        finish_run();
    end

endmodule